// File: doc/BRIEF.md
# Exclusive Two-Level Line Cache

This block caches 64-byte lines in two levels that never share a line. The near level is direct-mapped with 16 sets. The far level is a fully associative victim store with 8 slots. A requester issues one word-sized access at a time over a valid/ready port. The access carries a byte address, a store flag, a 32-bit data word and a 4-bit byte enable. A read gets its answer as a one-cycle response pulse. Behind the block, a line-wide valid/ready port reaches backing memory. Over that port the block fetches missing lines and writes dirty lines back.

The near level is the only place where accesses are served. A miss in both levels fetches the line from memory straight into the near level, and a store miss does the same before it merges its bytes. The line displaced from the near set is pushed down into the far level. If the far level has no free slot, a round-robin slot is given up first: it is written to memory when dirty and dropped when clean. A hit in the far level swaps that line with the line occupying its near set, and each line keeps its own dirty flag. While a fill, swap or write-back is in progress, the block refuses new requests.

Top module: `exc_cache`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid` and `mem_valid` are 0. Both levels are empty, so the first access to any line issues a memory read.
- R2: A read that hits the near level causes no memory traffic. `rsp_valid` is a single-cycle pulse on the second rising edge after the accepting edge. `rsp_rdata` carries the word at byte address bits [5:2], where byte k of a line sits at line bits [8k+7:8k].
- R3: A store applies enable bit i to data bits [8i+7:8i] of the addressed word. A store that misses both levels first reads the whole line from memory and then merges. A store with enable 0000 leaves the line unchanged.
- R4: A stored line is dirty. A dirty line reaches memory only when it is dropped from the far level. A clean line is never written to memory.
- R5: A memory fill goes only into the near level. The line displaced from that near set moves into the lowest free far slot, so a later access to it needs no memory read.
- R6: A far-level hit swaps the line with the occupant of its near set, with no memory traffic. Each line keeps its dirty flag, so dirty data survives a round trip.
- R7: When the far level is full, the victim slot follows a round-robin pointer that starts at slot 0 and advances on each replacement. A dirty victim is written to memory with its own line address and data before the pushed-down line takes its slot. Memory writes happen only while the far level is full.
- R8: No line address is valid in both levels at once, and no line address is valid in two far slots.
- R9: `req_ready` falls after an accepted request and stays low until the response cycle. `mem_valid`, `mem_we` and `mem_line` hold steady until `mem_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_we | input | 1 | 1 = store, 0 = load |
| req_addr | input | 12 | Byte address, word aligned |
| req_wdata | input | 32 | Store data |
| req_be | input | 4 | Store byte enables |
| rsp_valid | output | 1 | Response pulse |
| rsp_rdata | output | 32 | Load data |
| mem_valid | output | 1 | Memory command present |
| mem_ready | input | 1 | Memory takes the command |
| mem_we | output | 1 | 1 = line write, 0 = line read |
| mem_line | output | 6 | Line address |
| mem_wline | output | 512 | Line data to write |
| mem_rvalid | input | 1 | Returned fill line present |
| mem_rline | input | 512 | Returned fill line |

## Verification
A lost or stale dirty flag does not show at once. It shows when the line later leaves the far level, as a missing or extra memory write, or as wrong data when the line is read back from memory. A broken swap or demotion shows on the very next access to the affected line: it costs an unexpected memory read, or it returns data from the wrong line. A duplicated line, or a round-robin pointer that advances at the wrong time, tends to show only several replacements later, as a write-back at the wrong moment. The stimulus therefore fills the far level on purpose and walks the pointer across both clean and dirty slots.

// File: rtl/exc_cache_pkg.sv
package exc_cache_pkg;
    localparam int ADDR_W     = 12;
    localparam int LINE_BYTES = 64;
    localparam int WORD_BYTES = 4;
    localparam int L1_SETS    = 16;
    localparam int L2_WAYS    = 8;

    localparam int OFF_W     = $clog2(LINE_BYTES);
    localparam int BOFF_W    = $clog2(WORD_BYTES);
    localparam int WSEL_W    = OFF_W - BOFF_W;
    localparam int IDX_W     = $clog2(L1_SETS);
    localparam int LADDR_W   = ADDR_W - OFF_W;
    localparam int TAG_W     = LADDR_W - IDX_W;
    localparam int WAY_W     = $clog2(L2_WAYS);
    localparam int LINE_BITS = LINE_BYTES * 8;
    localparam int WORD_BITS = WORD_BYTES * 8;

    typedef logic [LINE_BITS-1:0] line_t;
    typedef logic [WORD_BITS-1:0] word_t;
    typedef logic [LADDR_W-1:0]   laddr_t;

    typedef enum logic [2:0] {
        S_IDLE, S_LOOK, S_WB, S_FETCH, S_WAIT
    } state_t;

    function automatic word_t get_word(line_t l, logic [WSEL_W-1:0] sel);
        return l[int'(sel) * WORD_BITS +: WORD_BITS];
    endfunction

    function automatic line_t put_word(line_t l, logic [WSEL_W-1:0] sel,
                                       word_t w, logic [WORD_BYTES-1:0] be);
        line_t r;
        r = l;
        for (int b = 0; b < WORD_BYTES; b++) begin
            if (be[b]) r[(int'(sel) * WORD_BYTES + b) * 8 +: 8] = w[b*8 +: 8];
        end
        return r;
    endfunction
endpackage

// File: rtl/exc_l1_store.sv
module exc_l1_store
    import exc_cache_pkg::*;
#(
    parameter int SETS = L1_SETS,
    parameter int TW   = TAG_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [$clog2(SETS)-1:0] idx,
    input  logic                    we,
    input  logic                    wvalid,
    input  logic                    wdirty,
    input  logic [TW-1:0]           wtag,
    input  line_t                   wline,
    output logic                    rvalid,
    output logic                    rdirty,
    output logic [TW-1:0]           rtag,
    output line_t                   rline,
    output logic [SETS-1:0]         valid_all,
    output logic [SETS*TW-1:0]      tag_all
);
    logic [SETS-1:0] valid_q, dirty_q;
    logic [TW-1:0]   tag_q  [SETS];
    line_t           data_q [SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (we) begin
            valid_q[idx] <= wvalid;
            dirty_q[idx] <= wdirty;
        end
    end

    always_ff @(posedge clk) begin
        if (we) begin
            tag_q[idx]  <= wtag;
            data_q[idx] <= wline;
        end
    end

    assign rvalid    = valid_q[idx];
    assign rdirty    = dirty_q[idx];
    assign rtag      = tag_q[idx];
    assign rline     = data_q[idx];
    assign valid_all = valid_q;

    for (genvar s = 0; s < SETS; s++) begin : g_tag_out
        assign tag_all[s*TW +: TW] = tag_q[s];
    end
endmodule

// File: rtl/exc_l2_store.sv
module exc_l2_store
    import exc_cache_pkg::*;
#(
    parameter int WAYS = L2_WAYS,
    parameter int LW   = LADDR_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [LW-1:0]           look_laddr,
    input  logic                    we,
    input  logic [$clog2(WAYS)-1:0] wway,
    input  logic                    wvalid,
    input  logic                    wdirty,
    input  logic [LW-1:0]           wladdr,
    input  line_t                   wline,
    input  logic                    rr_adv,
    output logic                    hit,
    output logic [$clog2(WAYS)-1:0] hit_way,
    output logic                    hit_dirty,
    output line_t                   hit_line,
    output logic                    has_free,
    output logic [$clog2(WAYS)-1:0] free_way,
    output logic [$clog2(WAYS)-1:0] vic_way,
    output logic                    vic_dirty,
    output logic [LW-1:0]           vic_laddr,
    output line_t                   vic_line,
    output logic [WAYS-1:0]         valid_all,
    output logic [WAYS*LW-1:0]      laddr_all
);
    localparam int WW = $clog2(WAYS);

    logic [WAYS-1:0] valid_q, dirty_q;
    logic [LW-1:0]   laddr_q [WAYS];
    line_t           data_q  [WAYS];
    logic [WW-1:0]   rr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            dirty_q <= '0;
            rr_q    <= '0;
        end else begin
            if (we) begin
                valid_q[wway] <= wvalid;
                dirty_q[wway] <= wdirty;
            end
            if (rr_adv) rr_q <= (int'(rr_q) == WAYS - 1) ? '0 : rr_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (we) begin
            laddr_q[wway] <= wladdr;
            data_q[wway]  <= wline;
        end
    end

    always_comb begin
        hit      = 1'b0;
        hit_way  = '0;
        has_free = 1'b0;
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (valid_q[w] && laddr_q[w] == look_laddr) begin
                hit     = 1'b1;
                hit_way = WW'(w);
            end
            if (!valid_q[w]) begin
                has_free = 1'b1;
                free_way = WW'(w);
            end
        end
    end

    assign hit_dirty = dirty_q[hit_way];
    assign hit_line  = data_q[hit_way];
    assign vic_way   = rr_q;
    assign vic_dirty = dirty_q[rr_q];
    assign vic_laddr = laddr_q[rr_q];
    assign vic_line  = data_q[rr_q];
    assign valid_all = valid_q;

    for (genvar w = 0; w < WAYS; w++) begin : g_laddr_out
        assign laddr_all[w*LW +: LW] = laddr_q[w];
    end
endmodule

// File: rtl/exc_cache.sv
module exc_cache
    import exc_cache_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic                  req_we,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [WORD_BITS-1:0]  req_wdata,
    input  logic [WORD_BYTES-1:0] req_be,
    output logic                  rsp_valid,
    output logic [WORD_BITS-1:0]  rsp_rdata,
    output logic                  mem_valid,
    input  logic                  mem_ready,
    output logic                  mem_we,
    output logic [LADDR_W-1:0]    mem_line,
    output logic [LINE_BITS-1:0]  mem_wline,
    input  logic                  mem_rvalid,
    input  logic [LINE_BITS-1:0]  mem_rline
);
    state_t                state_q, state_d;
    logic [ADDR_W-1:0]     q_addr;
    logic                  q_we;
    word_t                 q_wdata;
    logic [WORD_BYTES-1:0] q_be;

    logic [IDX_W-1:0]  idx;
    logic [TAG_W-1:0]  tag;
    laddr_t            laddr;
    logic [WSEL_W-1:0] wsel;

    assign laddr = q_addr[ADDR_W-1:OFF_W];
    assign idx   = laddr[IDX_W-1:0];
    assign tag   = laddr[LADDR_W-1:IDX_W];
    assign wsel  = q_addr[BOFF_W +: WSEL_W];

    // near level signals
    logic             l1_we, l1_wvalid, l1_wdirty, l1_v, l1_d;
    logic [TAG_W-1:0] l1_wtag, l1_tag;
    line_t            l1_wline, l1_line;
    logic [L1_SETS-1:0]       l1_valid_all;
    logic [L1_SETS*TAG_W-1:0] l1_tag_all;

    // far level signals
    logic               l2_we, l2_wvalid, l2_wdirty, rr_adv;
    logic [WAY_W-1:0]   l2_wway, l2_hit_way, l2_free_way, l2_vic_way;
    laddr_t             l2_wladdr, l2_vic_laddr;
    line_t              l2_wline, l2_hit_line, l2_vic_line;
    logic               l2_hit, l2_hit_dirty, l2_has_free, l2_vic_dirty;
    logic [L2_WAYS-1:0]         l2_valid_all;
    logic [L2_WAYS*LADDR_W-1:0] l2_laddr_all;

    logic   l1_hit;
    laddr_t l1_vic_laddr;
    assign l1_hit       = l1_v && (l1_tag == tag);
    assign l1_vic_laddr = {l1_tag, idx};

    exc_l1_store u_l1 (
        .clk(clk), .rst(rst), .idx(idx),
        .we(l1_we), .wvalid(l1_wvalid), .wdirty(l1_wdirty), .wtag(l1_wtag), .wline(l1_wline),
        .rvalid(l1_v), .rdirty(l1_d), .rtag(l1_tag), .rline(l1_line),
        .valid_all(l1_valid_all), .tag_all(l1_tag_all)
    );

    exc_l2_store u_l2 (
        .clk(clk), .rst(rst), .look_laddr(laddr),
        .we(l2_we), .wway(l2_wway), .wvalid(l2_wvalid), .wdirty(l2_wdirty),
        .wladdr(l2_wladdr), .wline(l2_wline), .rr_adv(rr_adv),
        .hit(l2_hit), .hit_way(l2_hit_way), .hit_dirty(l2_hit_dirty), .hit_line(l2_hit_line),
        .has_free(l2_has_free), .free_way(l2_free_way),
        .vic_way(l2_vic_way), .vic_dirty(l2_vic_dirty), .vic_laddr(l2_vic_laddr),
        .vic_line(l2_vic_line),
        .valid_all(l2_valid_all), .laddr_all(l2_laddr_all)
    );

    always_comb begin
        state_d   = state_q;
        l1_we     = 1'b0;
        l1_wvalid = 1'b1;
        l1_wdirty = 1'b0;
        l1_wtag   = tag;
        l1_wline  = l1_line;
        l2_we     = 1'b0;
        l2_wway   = l2_vic_way;
        l2_wvalid = l1_v;
        l2_wdirty = l1_d;
        l2_wladdr = l1_vic_laddr;
        l2_wline  = l1_line;
        rr_adv    = 1'b0;
        mem_valid = 1'b0;
        mem_we    = 1'b0;
        mem_line  = laddr;
        mem_wline = l2_vic_line;
        req_ready = (state_q == S_IDLE);
        unique case (state_q)
            S_IDLE: if (req_valid) state_d = S_LOOK;
            S_LOOK: begin
                if (l1_hit) begin
                    if (q_we) begin
                        l1_we     = 1'b1;
                        l1_wdirty = 1'b1;
                        l1_wline  = put_word(l1_line, wsel, q_wdata, q_be);
                    end
                    state_d = S_IDLE;
                end else if (l2_hit) begin
                    // swap: far line moves up, near occupant moves down
                    l1_we     = 1'b1;
                    l1_wdirty = l2_hit_dirty;
                    l1_wline  = l2_hit_line;
                    l2_we     = 1'b1;
                    l2_wway   = l2_hit_way;
                end else if (!l1_v) begin
                    state_d = S_FETCH;
                end else if (l2_has_free) begin
                    l2_we     = 1'b1;
                    l2_wway   = l2_free_way;
                    l1_we     = 1'b1;
                    l1_wvalid = 1'b0;
                    state_d   = S_FETCH;
                end else if (l2_vic_dirty) begin
                    state_d = S_WB;
                end else begin
                    l2_we     = 1'b1;
                    rr_adv    = 1'b1;
                    l1_we     = 1'b1;
                    l1_wvalid = 1'b0;
                    state_d   = S_FETCH;
                end
            end
            S_WB: begin
                mem_valid = 1'b1;
                mem_we    = 1'b1;
                mem_line  = l2_vic_laddr;
                if (mem_ready) begin
                    l2_we     = 1'b1;
                    rr_adv    = 1'b1;
                    l1_we     = 1'b1;
                    l1_wvalid = 1'b0;
                    state_d   = S_FETCH;
                end
            end
            S_FETCH: begin
                mem_valid = 1'b1;
                if (mem_ready) state_d = S_WAIT;
            end
            S_WAIT: begin
                if (mem_rvalid) begin
                    l1_we    = 1'b1;
                    l1_wline = mem_rline;
                    state_d  = S_LOOK;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= S_IDLE;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            q_addr    <= '0;
            q_we      <= 1'b0;
            q_wdata   <= '0;
            q_be      <= '0;
        end else begin
            state_q   <= state_d;
            rsp_valid <= (state_q == S_LOOK) && l1_hit;
            if (state_q == S_LOOK && l1_hit) rsp_rdata <= get_word(l1_line, wsel);
            if (req_valid && req_ready) begin
                q_addr  <= req_addr;
                q_we    <= req_we;
                q_wdata <= req_wdata;
                q_be    <= req_be;
            end
        end
    end
endmodule

// File: rtl/exc_cache_chk.sv
module exc_cache_chk
    import exc_cache_pkg::*;
(
    input logic                       clk,
    input logic                       rst,
    input logic                       req_valid,
    input logic                       req_ready,
    input logic                       rsp_valid,
    input logic                       mem_valid,
    input logic                       mem_ready,
    input logic                       mem_we,
    input logic [LADDR_W-1:0]         mem_line,
    input logic [L1_SETS-1:0]         l1_valid,
    input logic [L1_SETS*TAG_W-1:0]   l1_tags,
    input logic [L2_WAYS-1:0]         l2_valid,
    input logic [L2_WAYS*LADDR_W-1:0] l2_laddrs
);
    logic excl_bad, dup_bad;

    always_comb begin
        excl_bad = 1'b0;
        dup_bad  = 1'b0;
        for (int w = 0; w < L2_WAYS; w++) begin
            logic [LADDR_W-1:0] la;
            la = l2_laddrs[w*LADDR_W +: LADDR_W];
            if (l2_valid[w] && l1_valid[int'(la[IDX_W-1:0])] &&
                l1_tags[int'(la[IDX_W-1:0])*TAG_W +: TAG_W] == la[LADDR_W-1:IDX_W])
                excl_bad = 1'b1;
            for (int v = w + 1; v < L2_WAYS; v++) begin
                if (l2_valid[w] && l2_valid[v] &&
                    l2_laddrs[v*LADDR_W +: LADDR_W] == la)
                    dup_bad = 1'b1;
            end
        end
    end

    p_exclusive_r8: assert property (@(posedge clk) disable iff (rst) !excl_bad);
    p_far_unique_r8: assert property (@(posedge clk) disable iff (rst) !dup_bad);
    p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready |=> !req_ready);
    p_mem_hold_r9: assert property (@(posedge clk) disable iff (rst)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_we) && $stable(mem_line));
    p_rsp_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);
    p_rsp_idle_r9: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> req_ready);
    p_wb_when_full_r7: assert property (@(posedge clk) disable iff (rst)
        mem_valid && mem_we |-> &l2_valid);
endmodule

bind exc_cache exc_cache_chk u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_we(mem_we), .mem_line(mem_line),
    .l1_valid(l1_valid_all), .l1_tags(l1_tag_all),
    .l2_valid(l2_valid_all), .l2_laddrs(l2_laddr_all)
);

// File: tb/exc_cache_bench.sv
module exc_cache_bench;
    import exc_cache_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_we = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    word_t req_wdata = '0;
    logic [WORD_BYTES-1:0] req_be = '0;
    logic req_ready, rsp_valid;
    word_t rsp_rdata;
    logic mem_valid, mem_we;
    logic mem_ready = 1'b1;
    logic [LADDR_W-1:0] mem_line;
    line_t mem_wline;
    logic mem_rvalid = 1'b0;
    line_t mem_rline = '0;

    always #10ns clk = ~clk;

    exc_cache u_exc_cache (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
        .mem_line(mem_line), .mem_wline(mem_wline),
        .mem_rvalid(mem_rvalid), .mem_rline(mem_rline)
    );

    localparam int NBYTES = 1 << ADDR_W;
    logic [7:0] mem_b [NBYTES];
    logic [7:0] ref_b [NBYTES];
    int rd_cnt = 0, wr_cnt = 0;
    int checks = 0, fails = 0;
    bit done = 0;

    // we, addr, data, be, memory reads, memory writes, near hit
    typedef struct packed {
        logic        we;
        logic [11:0] addr;
        logic [31:0] data;
        logic [3:0]  be;
        logic [1:0]  nrd;
        logic [1:0]  nwr;
        logic        hit;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 12'h000, 32'h0,         4'h0, 2'd1, 2'd0, 1'b0}, // cold miss R1/R5
        '{1'b1, 12'h004, 32'hA5A5_0001, 4'hF, 2'd0, 2'd0, 1'b1}, // store hit R3
        '{1'b0, 12'h004, 32'h0,         4'h0, 2'd0, 2'd0, 1'b1}, // R2
        '{1'b0, 12'h400, 32'h0,         4'h0, 2'd1, 2'd0, 1'b0}, // demote to free slot R5
        '{1'b0, 12'h004, 32'h0,         4'h0, 2'd0, 2'd0, 1'b0}, // far hit swap R6
        '{1'b1, 12'h800, 32'h0000_BEEF, 4'h3, 2'd1, 2'd0, 1'b0}, // store miss allocate R3
        '{1'b0, 12'h800, 32'h0,         4'h0, 2'd0, 2'd0, 1'b1},
        '{1'b1, 12'h044, 32'hC0DE_0002, 4'hF, 2'd1, 2'd0, 1'b0},
        '{1'b0, 12'h440, 32'h0,         4'h0, 2'd1, 2'd0, 1'b0},
        '{1'b0, 12'h080, 32'h0,         4'h0, 2'd1, 2'd0, 1'b0},
        '{1'b0, 12'h480, 32'h0,         4'h0, 2'd1, 2'd0, 1'b0},
        '{1'b0, 12'h0C0, 32'h0,         4'h0, 2'd1, 2'd0, 1'b0},
        '{1'b0, 12'h4C0, 32'h0,         4'h0, 2'd1, 2'd0, 1'b0},
        '{1'b0, 12'h100, 32'h0,         4'h0, 2'd1, 2'd0, 1'b0},
        '{1'b0, 12'h500, 32'h0,         4'h0, 2'd1, 2'd0, 1'b0},
        '{1'b0, 12'h140, 32'h0,         4'h0, 2'd1, 2'd0, 1'b0},
        '{1'b0, 12'h540, 32'h0,         4'h0, 2'd1, 2'd0, 1'b0},
        '{1'b0, 12'h180, 32'h0,         4'h0, 2'd1, 2'd0, 1'b0},
        '{1'b0, 12'h580, 32'h0,         4'h0, 2'd1, 2'd0, 1'b0}, // far level now full
        '{1'b0, 12'hC00, 32'h0,         4'h0, 2'd1, 2'd0, 1'b0}, // slot0 clean dropped R7
        '{1'b0, 12'h004, 32'h0,         4'h0, 2'd0, 2'd0, 1'b0}, // dirty survives swap R6
        '{1'b0, 12'h400, 32'h0,         4'h0, 2'd1, 2'd0, 1'b0}, // slot1 clean dropped R7
        '{1'b0, 12'hC00, 32'h0,         4'h0, 2'd1, 2'd1, 1'b0}, // slot2 dirty written R4/R7
        '{1'b0, 12'h044, 32'h0,         4'h0, 2'd1, 2'd0, 1'b0}, // data from write-back R4
        '{1'b0, 12'h004, 32'h0,         4'h0, 2'd0, 2'd0, 1'b0},
        '{1'b0, 12'h800, 32'h0,         4'h0, 2'd0, 2'd0, 1'b0},
        '{1'b1, 12'h804, 32'hFFFF_FFFF, 4'h0, 2'd0, 2'd0, 1'b1}, // empty enable R3
        '{1'b0, 12'h804, 32'h0,         4'h0, 2'd0, 2'd0, 1'b1}
    };

    function automatic logic [7:0] init_byte(int a);
        return 8'((a * 37 + (a >> 6) * 11) ^ 8'h5A);
    endfunction

    function automatic word_t ref_word(logic [ADDR_W-1:0] a);
        word_t w;
        for (int b = 0; b < WORD_BYTES; b++) w[b*8 +: 8] = ref_b[int'(a) + b];
        return w;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // memory model, acts at falling edges
    initial begin
        logic pend;
        logic [LADDR_W-1:0] pend_line;
        pend = 1'b0;
        pend_line = '0;
        for (int a = 0; a < NBYTES; a++) begin
            mem_b[a] = init_byte(a);
            ref_b[a] = init_byte(a);
        end
        forever begin
            @(negedge clk);
            if (pend) begin
                mem_rvalid = 1'b1;
                for (int j = 0; j < LINE_BYTES; j++)
                    mem_rline[j*8 +: 8] = mem_b[int'(pend_line) * LINE_BYTES + j];
                pend = 1'b0;
            end else begin
                mem_rvalid = 1'b0;
            end
            if (!rst && mem_valid && !mem_we) begin
                pend = 1'b1;
                pend_line = mem_line;
                rd_cnt++;
            end
            if (!rst && mem_valid && mem_we) begin
                for (int j = 0; j < LINE_BYTES; j++)
                    mem_b[int'(mem_line) * LINE_BYTES + j] = mem_wline[j*8 +: 8];
                wr_cnt++;
            end
        end
    end

    // called at a falling edge with the block idle
    task automatic do_req(input vec_t v, input int row);
        int rd0, wr0, lat;
        bit got, busy_ok;
        word_t exp;
        rd0 = rd_cnt;
        wr0 = wr_cnt;
        exp = ref_word(v.addr);
        req_valid = 1'b1;
        req_we    = v.we;
        req_addr  = v.addr;
        req_wdata = v.data;
        req_be    = v.be;
        @(posedge clk);
        if (v.we) begin
            for (int b = 0; b < WORD_BYTES; b++)
                if (v.be[b]) ref_b[int'(v.addr) + b] = v.data[b*8 +: 8];
        end
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        got = 0;
        busy_ok = 1;
        while (!got && lat < 60) begin
            if (rsp_valid) got = 1;
            else begin
                if (req_ready) busy_ok = 0;
                @(negedge clk);
                lat++;
            end
        end
        check(got, "R9", $sformatf("row %0d response arrives", row), longint'(got), 1);
        check(busy_ok, "R9", $sformatf("row %0d ready low while busy", row), longint'(busy_ok), 1);
        check(rd_cnt - rd0 == int'(v.nrd), "R5", $sformatf("row %0d memory reads", row),
              rd_cnt - rd0, v.nrd);
        check(wr_cnt - wr0 == int'(v.nwr), "R4", $sformatf("row %0d memory writes", row),
              wr_cnt - wr0, v.nwr);
        if (!v.we)
            check(rsp_rdata == exp, "R2", $sformatf("row %0d read data", row), rsp_rdata, exp);
        if (v.hit)
            check(lat == 2, "R2", $sformatf("row %0d near hit latency", row), lat, 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
        check(rsp_valid == 1'b0, "R1", "no response after reset", rsp_valid, 0);
        check(mem_valid == 1'b0, "R1", "no memory command after reset", mem_valid, 0);

        for (int i = 0; i < NV; i++) do_req(VEC[i], i);

        // R1: a reset empties both levels; line 0 is cached again from memory
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready == 1'b1 && rsp_valid == 1'b0 && mem_valid == 1'b0, "R1",
              "idle outputs after second reset", {req_ready, rsp_valid, mem_valid}, 3'b100);
        for (int a = 0; a < NBYTES; a++) ref_b[a] = mem_b[a];
        do_req('{1'b0, 12'h004, 32'h0, 4'h0, 2'd1, 2'd0, 1'b0}, 100);
        do_req('{1'b0, 12'h008, 32'h0, 4'h0, 2'd0, 2'd0, 1'b1}, 101);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule